// File: doc/BRIEF.md
# External Trigger Conditioner

This block prepares one asynchronous trigger pin for use inside a timer. The pin passes through a two-flop synchroniser into the core clock domain. A configurable inversion then decides whether a high level or a low level counts as active. After that, a digital glitch filter moves its output only when enough consecutive samples agree. The filter's sample rate and the number of agreeing samples it needs both come from a 4-bit code.

The filtered level drives two outputs. `trig_level` is the conditioned active level. `trig_pulse` is a one-cycle strobe that an edge prescaler raises on every 1st, 2nd, 4th or 8th rising edge of that level. A timer downstream uses the level for gating and the strobe as a count or start event.

All configuration arrives on one static 16-bit word. The ratio between the core clock and the filter's base sampling clock is a build-time parameter, `DTS_RATIO`.

Top module: `ext_trig_conditioner`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `trig_level` and `trig_pulse` are both 0.
- R2: Bit 15 of `cfg_word` sets polarity. At 0 a high pin is active. At 1 a low pin is active. `trig_level` shows the filtered active level.
- R3: With filter code 0 (`cfg_word[11:8]` = 0) a pin change is sampled once per base tick of `DTS_RATIO` core cycles. It reaches `trig_level` between 4 and 3+`DTS_RATIO` cycles after the first clock edge that sees it.
- R4: Filter codes 1, 2 and 3 sample every core cycle and need 2, 4 and 8 equal samples. A clean pin change reaches `trig_level` exactly N+3 cycles after the first edge that sees it.
- R5: Filter codes 4 to 15 sample at the base rate divided by D and need N samples. The pairs (D, N) are:
  - codes 4 and 5: D=2, N=6 and N=8
  - codes 6 and 7: D=4, N=6 and N=8
  - codes 8 and 9: D=8, N=6 and N=8
  - codes 10, 11, 12: D=16, N=5, 6, 8
  - codes 13, 14, 15: D=32, N=5, 6, 8

  With P = `DTS_RATIO`·D, a clean change appears between 4+(N-1)·P and 3+N·P cycles after the first edge that sees it.
- R6: A pin excursion that yields fewer than N differing samples leaves `trig_level` unchanged. One sample equal to the current output restarts the count, so two short excursions separated by such a sample are both rejected.
- R7: `cfg_word[13:12]` = 0, 1, 2 or 3 makes `trig_pulse` fire on every 1st, 2nd, 4th or 8th rising edge of `trig_level`. The pulse is high for exactly one cycle, on the cycle after the rise. It never fires at any other time.
- R8: Any change of `cfg_word[13:12]` restarts the edge count, so the next pulse falls on the full group count of rises after the change.
- R9: Bits 14 and 7:0 of `cfg_word` have no effect on either output. Changing them does not restart the edge count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| cfg_word | input | 16 | Static configuration: polarity bit 15, prescaler 13:12, filter 11:8 |
| trig_level | output | 1 | Filtered active trigger level (registered) |
| trig_pulse | output | 1 | One-cycle strobe per prescaled rising edge (registered) |

## Verification
A pin change lands on `trig_level` after three register stages plus the filter's N sampling ticks. For the core-rate codes this is an exact cycle count. For the ticked codes it falls in a window whose width is one tick period, because the tick counter runs freely. `trig_pulse` lands one cycle after the rise that completes a group.

The driver computes each due window from the filter table and queues it together with the expected pulse flag. The monitor compares every change of `trig_level` against that window. It then samples `trig_pulse` exactly one cycle later. Glitch stimulus is sized from N and P so that it produces too few samples, and the output is read after the longest window has passed.

// File: rtl/ext_trig_pkg.sv
package ext_trig_pkg;

  // Field placement inside the configuration word
  localparam int CFG_W     = 16;
  localparam int POL_BIT   = 15;
  localparam int PSC_LSB   = 12;
  localparam int PSC_W     = 2;
  localparam int FLT_LSB   = 8;
  localparam int FLT_W     = 4;
  localparam int MAX_SHIFT = 5;
  localparam int NEED_W    = 4;

  typedef struct packed {
    logic             invert;
    logic [PSC_W-1:0] presc;
    logic [FLT_W-1:0] filt;
  } trig_cfg_t;

  typedef struct packed {
    logic              core_rate;
    logic [2:0]        shift;
    logic [NEED_W-1:0] need;
  } filt_sel_t;

  function automatic trig_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    trig_cfg_t c;
    c.invert = w[POL_BIT];
    c.presc  = w[PSC_LSB +: PSC_W];
    c.filt   = w[FLT_LSB +: FLT_W];
    return c;
  endfunction

  // Sampling-rate selection and required agreeing-sample count per filter code
  function automatic filt_sel_t decode_filter(input logic [FLT_W-1:0] code);
    filt_sel_t s;
    s.core_rate = 1'b0;
    s.shift     = 3'd0;
    s.need      = 4'd1;
    case (code)
      4'd0:  begin s.need = 4'd1; end
      4'd1:  begin s.core_rate = 1'b1; s.need = 4'd2; end
      4'd2:  begin s.core_rate = 1'b1; s.need = 4'd4; end
      4'd3:  begin s.core_rate = 1'b1; s.need = 4'd8; end
      4'd4:  begin s.shift = 3'd1; s.need = 4'd6; end
      4'd5:  begin s.shift = 3'd1; s.need = 4'd8; end
      4'd6:  begin s.shift = 3'd2; s.need = 4'd6; end
      4'd7:  begin s.shift = 3'd2; s.need = 4'd8; end
      4'd8:  begin s.shift = 3'd3; s.need = 4'd6; end
      4'd9:  begin s.shift = 3'd3; s.need = 4'd8; end
      4'd10: begin s.shift = 3'd4; s.need = 4'd5; end
      4'd11: begin s.shift = 3'd4; s.need = 4'd6; end
      4'd12: begin s.shift = 3'd4; s.need = 4'd8; end
      4'd13: begin s.shift = 3'd5; s.need = 4'd5; end
      4'd14: begin s.shift = 3'd5; s.need = 4'd6; end
      default: begin s.shift = 3'd5; s.need = 4'd8; end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/etc_sync_pol.sv
module etc_sync_pol #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic invert,
  output logic active
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= pin;
        else chain[g] <= chain[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) active <= 1'b0;
    else     active <= chain[STAGES-1] ^ invert;
  end
endmodule

// File: rtl/etc_sample_tick.sv
module etc_sample_tick #(
  parameter int DTS_RATIO = 2,
  parameter int MAX_SHIFT = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       core_rate,
  input  logic [2:0] shift,
  output logic       tick
);
  localparam int MAX_PERIOD = DTS_RATIO << MAX_SHIFT;
  localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    if (core_rate) period = CNT_W'(1);
    else           period = CNT_W'(DTS_RATIO) << shift;
  end

  // Compare with >= so a shortened period takes effect at once
  assign tick = (cnt >= period - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/etc_glitch_filter.sv
module etc_glitch_filter
  import ext_trig_pkg::*;
#(
  parameter int CODE_W = FLT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic [NEED_W-1:0] need,
  input  logic              tick,
  input  logic              din,
  output logic              level,
  output logic              rise
);
  logic [NEED_W-1:0] agree;
  logic [CODE_W-1:0] code_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      level  <= 1'b0;
      rise   <= 1'b0;
      agree  <= '0;
      code_d <= '0;
    end else begin
      rise   <= 1'b0;
      code_d <= code;
      if (code != code_d) begin
        agree <= '0;
      end else if (tick) begin
        if (din == level) begin
          agree <= '0;
        end else if (agree + NEED_W'(1) >= need) begin
          level <= din;
          rise  <= din;
          agree <= '0;
        end else begin
          agree <= agree + NEED_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/etc_edge_prescaler.sv
module etc_edge_prescaler #(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PSC_W-1:0] code,
  input  logic             rise,
  output logic             pulse
);
  localparam int CNT_W = (1 << PSC_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_idx;
  logic [PSC_W-1:0] code_d;

  assign last_idx = ~({CNT_W{1'b1}} << code);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      code_d <= '0;
      pulse  <= 1'b0;
    end else begin
      code_d <= code;
      pulse  <= 1'b0;
      if (code != code_d) begin
        cnt <= '0;
      end else if (rise) begin
        if (cnt == last_idx) begin
          cnt   <= '0;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ext_trig_conditioner.sv
module ext_trig_conditioner
  import ext_trig_pkg::*;
#(
  parameter int DTS_RATIO   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_pin,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             trig_level,
  output logic             trig_pulse
);
  trig_cfg_t cfg;
  filt_sel_t sel;
  logic      pol_s;
  logic      tick_s;
  logic      rise_s;

  assign cfg = unpack_cfg(cfg_word);
  assign sel = decode_filter(cfg.filt);

  etc_sync_pol #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(trig_pin), .invert(cfg.invert), .active(pol_s)
  );

  etc_sample_tick #(.DTS_RATIO(DTS_RATIO), .MAX_SHIFT(MAX_SHIFT)) u_tick (
    .clk(clk), .rst(rst), .core_rate(sel.core_rate), .shift(sel.shift), .tick(tick_s)
  );

  etc_glitch_filter #(.CODE_W(FLT_W)) u_filt (
    .clk(clk), .rst(rst), .code(cfg.filt), .need(sel.need), .tick(tick_s),
    .din(pol_s), .level(trig_level), .rise(rise_s)
  );

  etc_edge_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .code(cfg.presc), .rise(rise_s), .pulse(trig_pulse)
  );
endmodule

// File: rtl/ext_trig_conditioner_chk.sv
module ext_trig_conditioner_chk (
  input logic       clk,
  input logic       rst,
  input logic       trig_pin,
  input logic       invert,
  input logic [1:0] presc,
  input logic [3:0] filt,
  input logic       trig_level,
  input logic       trig_pulse,
  input logic       pol_q,
  input logic       tick
);
  logic [1:0] age;
  logic       armed;

  always_ff @(posedge clk) begin
    if (rst)              age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign armed = (age == 2'd3);

  // R1: outputs cleared by reset
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!trig_level && !trig_pulse));

  // R2: active stage equals pin delayed by the synchroniser, xor polarity
  a_r2_polarity_path: assert property (@(posedge clk) disable iff (rst)
    armed |-> (pol_q == ($past(trig_pin, 3) ^ $past(invert))));

  // R3: level moves only on a sampling tick
  a_r3_change_on_tick: assert property (@(posedge clk) disable iff (rst)
    (armed && (trig_level != $past(trig_level))) |-> $past(tick));

  // R4: with code 1 a change needs two agreeing samples
  a_r4_two_agree: assert property (@(posedge clk) disable iff (rst)
    (armed && (trig_level != $past(trig_level)) &&
     ($past(filt) == 4'd1) && ($past(filt, 2) == 4'd1))
    |-> (($past(pol_q) == trig_level) && ($past(pol_q, 2) == trig_level)));

  // R7: pulse follows a rise of the level by one cycle
  a_r7_pulse_after_rise: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |-> ($past(trig_level) && !$past(trig_level, 2)));

  // R7: pulse lasts a single cycle
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |=> !trig_pulse);

  // R8: a prescaler code change suppresses a pulse in that cycle
  a_r8_no_pulse_on_write: assert property (@(posedge clk) disable iff (rst)
    (armed && ($past(presc) != $past(presc, 2))) |-> !trig_pulse);
endmodule

bind ext_trig_conditioner ext_trig_conditioner_chk u_chk (
  .clk(clk), .rst(rst), .trig_pin(trig_pin),
  .invert(cfg_word[15]), .presc(cfg_word[13:12]), .filt(cfg_word[11:8]),
  .trig_level(trig_level), .trig_pulse(trig_pulse),
  .pol_q(pol_s), .tick(tick_s)
);

// File: tb/test_ext_trig_conditioner.sv
`timescale 1ns/1ps
module test_ext_trig_conditioner;
  localparam int DTS = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin = 1'b0;
  logic [15:0] cfg = 16'h0000;
  logic        trig_level;
  logic        trig_pulse;

  always #4 clk = ~clk;

  ext_trig_conditioner #(.DTS_RATIO(DTS)) i_ext_trig_conditioner (
    .clk(clk), .rst(rst), .trig_pin(pin), .cfg_word(cfg),
    .trig_level(trig_level), .trig_pulse(trig_pulse)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    bit    lvl;
    int    lo;
    int    hi;
    bit    pul;
    string tag;
  } exp_t;
  exp_t q[$];

  bit cur_act = 1'b0;
  int psc_idx = 0;

  task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act_v, exp_v, cyc);
    end
  endtask

  function automatic int need_of(input logic [3:0] c);
    case (c)
      4'd0: return 1;
      4'd1: return 2;
      4'd2: return 4;
      4'd3: return 8;
      4'd4, 4'd6, 4'd8: return 6;
      4'd10, 4'd13: return 5;
      4'd11, 4'd14: return 6;
      default: return 8;
    endcase
  endfunction

  function automatic int per_of(input logic [3:0] c);
    if (c == 4'd0) return DTS;
    if (c <= 4'd3) return 1;
    if (c <= 4'd9) return DTS << ((int'(c) - 4) / 2 + 1);
    if (c <= 4'd12) return DTS << 4;
    return DTS << 5;
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    if (c == 4'd0) return "R3";
    if (c <= 4'd3) return "R4";
    return "R5";
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_psc(input logic [1:0] p);
    cfg[13:12] = p;
    psc_idx = 0;
    wait_cyc(3);
  endtask

  // Driver: move the active level and queue the expected result window
  task automatic drive(input bit a);
    exp_t e;
    int n, p, dv;
    n = need_of(cfg[11:8]);
    p = per_of(cfg[11:8]);
    dv = 1 << cfg[13:12];
    pin = a ^ cfg[15];
    e.lvl = a;
    e.lo  = cyc + 4 + (n - 1) * p;
    e.hi  = cyc + 3 + n * p;
    e.tag = tag_of(cfg[11:8]);
    e.pul = 1'b0;
    if (a) begin
      e.pul = ((psc_idx % dv) == dv - 1);
      psc_idx++;
    end
    q.push_back(e);
    cur_act = a;
    wait_cyc(3 + n * p + 4);
  endtask

  // Excursion too short to pass the filter; level must stay put (R6)
  task automatic glitch(input int g, input int gap, input int g2);
    int n, p;
    n = need_of(cfg[11:8]);
    p = per_of(cfg[11:8]);
    pin = (~cur_act) ^ cfg[15];
    wait_cyc(g);
    pin = cur_act ^ cfg[15];
    if (gap > 0) begin
      wait_cyc(gap);
      pin = (~cur_act) ^ cfg[15];
      wait_cyc(g2);
      pin = cur_act ^ cfg[15];
    end
    wait_cyc(3 + n * p + 4);
    check(trig_level == cur_act, "R6 glitch rejected", trig_level, cur_act);
  endtask

  function automatic int glen(input logic [3:0] c);
    int p;
    p = per_of(c);
    return (need_of(c) - 1) * p - ((p > 1) ? 1 : 0);
  endfunction

  // Monitor: compares level changes and pulses against the queue
  bit   prev_lvl = 1'b0;
  bit   pend = 1'b0;
  bit   pend_pul = 1'b0;
  exp_t m;
  always @(negedge clk) begin
    if (!rst) begin
      if (pend) begin
        check(trig_pulse == pend_pul, "R7 pulse after rise", trig_pulse, pend_pul);
        pend = 1'b0;
      end else if (trig_pulse) begin
        check(1'b0, "R7 unexpected pulse", 1, 0);
      end
      if (trig_level != prev_lvl) begin
        if (q.size() == 0) begin
          check(1'b0, "R6 unexpected level change", trig_level, prev_lvl);
        end else begin
          m = q.pop_front();
          check(trig_level == m.lvl, m.tag, trig_level, m.lvl);
          check((cyc >= m.lo) && (cyc <= m.hi), {m.tag, " latency window"}, cyc, m.lo);
          if (trig_level) begin
            pend = 1'b1;
            pend_pul = m.pul;
          end
        end
      end
      prev_lvl = trig_level;
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    wait_cyc(5);
    check(trig_level == 1'b0, "R1 level in reset", trig_level, 0);
    check(trig_pulse == 1'b0, "R1 pulse in reset", trig_pulse, 0);
    rst = 1'b0;
    @(negedge clk);
    check(trig_level == 1'b0, "R1 level after reset", trig_level, 0);
    check(trig_pulse == 1'b0, "R1 pulse after reset", trig_pulse, 0);
    wait_cyc(4);

    // R3, R4, R5: latency for each filter code, prescaler divide-by-1
    for (int c = 0; c < 16; c++) begin
      cfg[11:8] = 4'(c);
      wait_cyc(3);
      drive(1'b1);
      drive(1'b0);
    end

    // R6: short excursions rejected for several codes
    cfg[11:8] = 4'd3; wait_cyc(3);
    glitch(glen(4'd3), 0, 0);
    glitch(7, 1, 7);
    cfg[11:8] = 4'd5; wait_cyc(3);
    glitch(glen(4'd5), 0, 0);
    cfg[11:8] = 4'd12; wait_cyc(3);
    glitch(glen(4'd12), 0, 0);
    cfg[11:8] = 4'd2; wait_cyc(3);
    drive(1'b1);
    glitch(glen(4'd2), 0, 0);
    drive(1'b0);

    // R2: switch to active-low together with the pin; transient filtered out
    cfg[11:8] = 4'd3; wait_cyc(3);
    cfg[15] = 1'b1;
    pin = 1'b1;
    wait_cyc(20);
    check(trig_level == 1'b0, "R2 idle with inverted polarity", trig_level, 0);
    drive(1'b1);
    check(pin == 1'b0 && trig_level == 1'b1, "R2 low pin is active", trig_level, 1);
    drive(1'b0);
    cfg[15] = 1'b0;
    pin = 1'b0;
    wait_cyc(20);
    check(trig_level == 1'b0, "R2 back to active-high", trig_level, 0);

    // R7: prescaler divide by 1, 2, 4, 8
    cfg[11:8] = 4'd1; wait_cyc(3);
    for (int p = 0; p < 4; p++) begin
      set_psc(2'(p));
      for (int k = 0; k < 8; k++) begin
        drive(1'b1);
        drive(1'b0);
      end
    end

    // R8: code change restarts the group count
    set_psc(2'd3);
    for (int k = 0; k < 3; k++) begin drive(1'b1); drive(1'b0); end
    set_psc(2'd2);
    for (int k = 0; k < 4; k++) begin drive(1'b1); drive(1'b0); end

    // R9: unrelated bits toggled mid-group do not restart or disturb
    set_psc(2'd2);
    for (int k = 0; k < 2; k++) begin drive(1'b1); drive(1'b0); end
    cfg[14] = 1'b1;
    cfg[7:0] = 8'hA5;
    wait_cyc(3);
    for (int k = 0; k < 2; k++) begin drive(1'b1); drive(1'b0); end
    check(trig_level == 1'b0, "R9 ignored bits", trig_level, 0);

    wait_cyc(20);
    check(q.size() == 0, "R7 all expected events seen", q.size(), 0);
    finish_run();
  end
endmodule